// File: doc/BRIEF.md
# Virtual Output Queue Input Buffer

This block sits on the input side of an N-port switched backplane and holds fixed-size cells until a central allocator lets them cross. Every destination port has its own logical FIFO. All of these FIFOs are linked lists threaded through one shared pool of cell slots, and a bitmap tracks which slots are free. A cell waiting for a busy or back-pressured output therefore never holds up cells that are bound elsewhere.

A cell arrives as eight 64-bit beats, and its destination is taken from the first beat. For each destination that is worth serving, the block raises one request bit to the allocator. A destination is worth serving when it has at least two cells queued, or when its single head cell has waited out a programmable timeout. A per-destination inhibit input holds that destination's request low. A one-hot grant, valid for one cycle, starts a transfer of two cells (sixteen beats) from the granted queue in arrival order. When only one cell was queued, the second half of the transfer is zero padding. If a cell arrives when no slot is free, or with a destination that does not exist, the whole cell is discarded and a one-cycle drop flag is raised.

Top module: `vq_input_buffer`

## Requirements
- R1: After reset, `request` is all zeros, `out_valid` is low and `drop_pulse` is low.
- R2: A cell is eight beats accepted while `in_valid` is high, and the destination is sampled on the first beat. The cell joins that destination's queue at the clock edge of its eighth beat. When that queue then holds two or more cells, `request[dest]` is high from the following cycle.
- R3: While a queue holds exactly one cell, its request stays low until that cell has been at the head of the queue for `cfg_timeout` cycles.
- R4: While `inhibit[d]` is high, `request[d]` is low, and the queued cells are kept. After inhibit is released, the request returns and the cells transfer intact.
- R5: A grant accepted in cycle T produces `out_valid` for 16 consecutive cycles, starting in cycle T+2. `out_dest` equals the granted port. Beats 0..7 carry the oldest cell and beats 8..15 carry the next one, each in beat order. `out_last` is high only on beat 15.
- R6: If the granted queue held one cell at grant time, beats 8..15 have `out_pad` high and `out_data` equal to zero.
- R7: A cell that starts when every slot is occupied is discarded whole. `drop_pulse` is high for exactly the one cycle after its first beat, and the cells already queued are delivered unchanged and in order.
- R8: A grant is ignored when it is not one-hot, when its destination is not requesting, or while a transfer is in progress.
- R9: An inhibited or unserved destination does not delay requests or transfers of other destinations.
- R10: A cell whose first-beat destination is N_DEST or greater is discarded, with `drop_pulse` as in R7.
- R11: The slots of transferred cells return to the pool and accept new cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMO_W (12) | Cycles a lone head cell waits before it requests |
| in_valid | input | 1 | Cell beat valid |
| in_dest | input | DEST_W (4) | Destination port, sampled on the first beat |
| in_data | input | BEAT_W (64) | Cell beat payload |
| drop_pulse | output | 1 | One-cycle flag for a discarded cell |
| inhibit | input | N_DEST (15) | Per-destination back-pressure |
| request | output | N_DEST (15) | Per-destination transfer request |
| grant | input | N_DEST (15) | One-hot grant, one cycle |
| out_valid | output | 1 | Transfer beat valid |
| out_dest | output | DEST_W (4) | Destination of the transfer in progress |
| out_data | output | BEAT_W (64) | Transfer beat payload |
| out_pad | output | 1 | Beat is padding |
| out_last | output | 1 | Final beat of the transfer |

## Verification
Queue refill is tried in several ways. One destination receives a pair of cells, and its lone first cell must stay silent. A single cell is left to age past the timeout, which separates count-based from time-based requests and checks the padded half. Two destinations are loaded while one of them is inhibited, which shows that neither back-pressure nor an ignored grant leaks into the other queue. Finally the pool is filled to its last slot and then overrun, which separates a clean drop from a corrupted list by draining sixteen cells in order and refilling the freed slots.

// File: rtl/vq_pkg.sv
package vq_pkg;
   typedef enum logic [0:0] {
      XF_IDLE = 1'b0,
      XF_RUN  = 1'b1
   } xf_state_e;
endpackage

// File: rtl/vq_free_pool.sv
module vq_free_pool #(
   parameter int SLOTS  = 16,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              rel,
   input  logic [SLOT_W-1:0] rel_slot,
   output logic              has_free,
   output logic [SLOT_W-1:0] alloc_slot
);
   logic [SLOTS-1:0] free_map;

   // lowest free slot wins
   always_comb begin
      has_free   = |free_map;
      alloc_slot = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (free_map[i]) alloc_slot = SLOT_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_map <= '1;
      end else begin
         if (alloc) free_map[alloc_slot] <= 1'b0;
         if (rel)   free_map[rel_slot]   <= 1'b1;
      end
   end
endmodule

// File: rtl/vq_link_table.sv
module vq_link_table #(
   parameter int N_DEST = 15,
   parameter int SLOTS  = 16,
   parameter int SLOT_W = 4,
   parameter int DEST_W = 4,
   parameter int CNT_W  = 5,
   parameter int TMO_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DEST_W-1:0] push_q,
   input  logic [SLOT_W-1:0] push_slot,
   input  logic              pop,
   input  logic [DEST_W-1:0] sel_q,
   input  logic [TMO_W-1:0]  cfg_timeout,
   output logic [SLOT_W-1:0] sel_head,
   output logic [N_DEST-1:0] eligible,
   output logic [N_DEST-1:0] multi
);
   logic [SLOT_W-1:0] head_q [N_DEST];
   logic [SLOT_W-1:0] tail_q [N_DEST];
   logic [CNT_W-1:0]  cnt_q  [N_DEST];
   logic [SLOT_W-1:0] next_q [SLOTS];

   logic push_to_empty;

   generate
      for (genvar q = 0; q < N_DEST; q++) begin : g_q
         logic [SLOT_W-1:0] head_r, tail_r;
         logic [CNT_W-1:0]  cnt_r;
         logic [TMO_W-1:0]  age_r;
         logic              p, o;

         assign p = push && (push_q == DEST_W'(q));
         assign o = pop  && (sel_q  == DEST_W'(q));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               head_r <= '0;
               tail_r <= '0;
               cnt_r  <= '0;
               age_r  <= '0;
            end else begin
               cnt_r <= cnt_r + CNT_W'(p) - CNT_W'(o);
               if (o) head_r <= next_q[head_r];
               if (p && (cnt_r == CNT_W'(o))) head_r <= push_slot;
               if (p) tail_r <= push_slot;
               if (o || (p && (cnt_r == '0)))
                  age_r <= '0;
               else if ((cnt_r != '0) && (age_r != '1))
                  age_r <= age_r + 1'b1;
            end
         end

         assign head_q[q]   = head_r;
         assign tail_q[q]   = tail_r;
         assign cnt_q[q]    = cnt_r;
         assign multi[q]    = cnt_r >= CNT_W'(2);
         assign eligible[q] = (cnt_r >= CNT_W'(2)) ||
                              ((cnt_r != '0) && (age_r >= cfg_timeout));
      end
   endgenerate

   assign push_to_empty = cnt_q[push_q] == CNT_W'(pop && (sel_q == push_q));
   assign sel_head      = head_q[sel_q];

   always_ff @(posedge clk) begin
      if (push && !push_to_empty) next_q[tail_q[push_q]] <= push_slot;
   end
endmodule

// File: rtl/vq_egress.sv
module vq_egress
   import vq_pkg::*;
#(
   parameter int N_DEST     = 15,
   parameter int DEST_W     = 4,
   parameter int CELL_BEATS = 8,
   parameter int BIDX_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DEST-1:0] grant,
   input  logic [N_DEST-1:0] request,
   input  logic [N_DEST-1:0] multi,
   output logic              busy,
   output logic [DEST_W-1:0] cur_q,
   output logic              rd_en,
   output logic [BIDX_W-1:0] rd_beat,
   output logic              rd_pad,
   output logic              rd_last,
   output logic              pop
);
   localparam int XB_W = BIDX_W + 1;

   xf_state_e         state;
   logic [XB_W-1:0]   beat;
   logic              two;
   logic              g_ok;
   logic [DEST_W-1:0] g_idx;

   always_comb begin
      g_idx = '0;
      for (int i = 0; i < N_DEST; i++) begin
         if (grant[i]) g_idx = DEST_W'(i);
      end
      g_ok = (state == XF_IDLE) && $onehot(grant) && |(grant & request);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= XF_IDLE;
         beat  <= '0;
         two   <= 1'b0;
         cur_q <= '0;
      end else if (state == XF_IDLE) begin
         if (g_ok) begin
            state <= XF_RUN;
            beat  <= '0;
            cur_q <= g_idx;
            two   <= multi[g_idx];
         end
      end else begin
         beat <= beat + 1'b1;
         if (beat == '1) state <= XF_IDLE;
      end
   end

   assign busy    = state == XF_RUN;
   assign rd_en   = busy;
   assign rd_beat = beat[BIDX_W-1:0];
   assign rd_pad  = beat[XB_W-1] && !two;
   assign rd_last = busy && (beat == '1);
   assign pop     = busy && (rd_beat == '1) && !rd_pad;
endmodule

// File: rtl/vq_input_buffer.sv
module vq_input_buffer #(
   parameter int N_DEST     = 15,
   parameter int BEAT_W     = 64,
   parameter int CELL_BEATS = 8,
   parameter int POOL_CELLS = 16,
   parameter int TMO_W      = 12,
   localparam int DEST_W    = $clog2(N_DEST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMO_W-1:0]  cfg_timeout,
   input  logic              in_valid,
   input  logic [DEST_W-1:0] in_dest,
   input  logic [BEAT_W-1:0] in_data,
   output logic              drop_pulse,
   input  logic [N_DEST-1:0] inhibit,
   output logic [N_DEST-1:0] request,
   input  logic [N_DEST-1:0] grant,
   output logic              out_valid,
   output logic [DEST_W-1:0] out_dest,
   output logic [BEAT_W-1:0] out_data,
   output logic              out_pad,
   output logic              out_last
);
   localparam int SLOT_W = $clog2(POOL_CELLS);
   localparam int BIDX_W = $clog2(CELL_BEATS);
   localparam int CNT_W  = $clog2(POOL_CELLS + 1);
   localparam int MEM_D  = POOL_CELLS * CELL_BEATS;

   generate
      if (N_DEST < 2) begin : g_bad_ndest
         $error("N_DEST must be at least 2");
      end
      if (CELL_BEATS < 2 || (1 << BIDX_W) != CELL_BEATS) begin : g_bad_beats
         $error("CELL_BEATS must be a power of two, at least 2");
      end
      if (POOL_CELLS < 2 || (1 << SLOT_W) != POOL_CELLS) begin : g_bad_pool
         $error("POOL_CELLS must be a power of two, at least 2");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("TMO_W must be positive");
      end
   endgenerate

   // ingress state
   logic [BIDX_W-1:0] in_beat;
   logic              keep_r;
   logic [SLOT_W-1:0] slot_r;
   logic [DEST_W-1:0] dest_r;
   logic              drop_r;

   logic              first, dest_ok, alloc, wr_en, push;
   logic [SLOT_W-1:0] wr_slot, alloc_slot, sel_head;
   logic [DEST_W-1:0] push_q, cur_q;
   logic              has_free;

   logic [N_DEST-1:0] eligible, multi;
   logic              busy, rd_en, rd_pad, rd_last, pop;
   logic [BIDX_W-1:0] rd_beat;

   logic [BEAT_W-1:0] mem [MEM_D];

   always_comb begin
      first   = in_valid && (in_beat == '0);
      dest_ok = {1'b0, in_dest} < (DEST_W + 1)'(N_DEST);
      alloc   = first && dest_ok && has_free;
      wr_slot = (in_beat == '0) ? alloc_slot : slot_r;
      wr_en   = in_valid && ((in_beat == '0) ? alloc : keep_r);
      push    = wr_en && (in_beat == '1);
      push_q  = (in_beat == '0) ? in_dest : dest_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_beat <= '0;
         keep_r  <= 1'b0;
         slot_r  <= '0;
         dest_r  <= '0;
         drop_r  <= 1'b0;
      end else begin
         drop_r <= first && !alloc;
         if (in_valid) begin
            in_beat <= in_beat + 1'b1;
            if (in_beat == '0) begin
               keep_r <= alloc;
               slot_r <= alloc_slot;
               dest_r <= in_dest;
            end
         end
      end
   end

   assign drop_pulse = drop_r;

   always_ff @(posedge clk) begin
      if (wr_en) mem[{wr_slot, in_beat}] <= in_data;
   end

   vq_free_pool #(
      .SLOTS  (POOL_CELLS),
      .SLOT_W (SLOT_W)
   ) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc),
      .rel        (pop),
      .rel_slot   (sel_head),
      .has_free   (has_free),
      .alloc_slot (alloc_slot)
   );

   vq_link_table #(
      .N_DEST (N_DEST),
      .SLOTS  (POOL_CELLS),
      .SLOT_W (SLOT_W),
      .DEST_W (DEST_W),
      .CNT_W  (CNT_W),
      .TMO_W  (TMO_W)
   ) u_links (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (push),
      .push_q      (push_q),
      .push_slot   (wr_slot),
      .pop         (pop),
      .sel_q       (cur_q),
      .cfg_timeout (cfg_timeout),
      .sel_head    (sel_head),
      .eligible    (eligible),
      .multi       (multi)
   );

   vq_egress #(
      .N_DEST     (N_DEST),
      .DEST_W     (DEST_W),
      .CELL_BEATS (CELL_BEATS),
      .BIDX_W     (BIDX_W)
   ) u_egress (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant),
      .request (request),
      .multi   (multi),
      .busy    (busy),
      .cur_q   (cur_q),
      .rd_en   (rd_en),
      .rd_beat (rd_beat),
      .rd_pad  (rd_pad),
      .rd_last (rd_last),
      .pop     (pop)
   );

   generate
      for (genvar q = 0; q < N_DEST; q++) begin : g_req
         assign request[q] = eligible[q] && !inhibit[q] &&
                             !(busy && (cur_q == DEST_W'(q)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pad   <= 1'b0;
         out_last  <= 1'b0;
         out_dest  <= '0;
      end else begin
         out_valid <= rd_en;
         out_pad   <= rd_en && rd_pad;
         out_last  <= rd_last;
         out_dest  <= cur_q;
      end
   end

   always_ff @(posedge clk) begin
      out_data <= rd_pad ? '0 : mem[{sel_head, rd_beat}];
   end
endmodule

// File: rtl/vq_input_buffer_chk.sv
module vq_input_buffer_chk #(
   parameter int N_DEST = 15,
   parameter int DEST_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_DEST-1:0] inhibit,
   input logic [N_DEST-1:0] request,
   input logic              out_valid,
   input logic              out_last,
   input logic              out_pad,
   input logic [DEST_W-1:0] out_dest,
   input logic              drop_pulse
);
   // R4: back-pressure always masks the request
   p_inhibit_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (request & inhibit) == '0);

   // R5: a transfer streams without gaps toward one destination
   p_burst_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |=> out_valid && $stable(out_dest));

   // R8: no new transfer can follow the last beat back to back
   p_gap_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |=> !out_valid);

   // R8: the queue being served does not request again mid-transfer
   p_own_req_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |-> !request[out_dest]);

   // R6: padding, once started, runs to the end of the transfer
   p_pad_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_pad && !out_last |=> out_valid && out_pad);

   // R7: a drop flag is a single-cycle pulse
   p_drop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_pulse |=> !drop_pulse);
endmodule

bind vq_input_buffer vq_input_buffer_chk #(
   .N_DEST (N_DEST),
   .DEST_W (DEST_W)
) u_chk (.*);

// File: tb/test_vq_input_buffer.sv
module test_vq_input_buffer;
   localparam int N  = 15;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   cfg_timeout = 12'd1000;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_dest = '0;
   logic [63:0]   in_data = '0;
   logic          drop_pulse;
   logic [N-1:0]  inhibit = '0;
   logic [N-1:0]  request;
   logic [N-1:0]  grant = '0;
   logic          out_valid;
   logic [DW-1:0] out_dest;
   logic [63:0]   out_data;
   logic          out_pad;
   logic          out_last;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   vq_input_buffer i_vq_input_buffer (
      .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
      .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
      .drop_pulse(drop_pulse), .inhibit(inhibit), .request(request),
      .grant(grant), .out_valid(out_valid), .out_dest(out_dest),
      .out_data(out_data), .out_pad(out_pad), .out_last(out_last)
   );

   function automatic logic [63:0] mk(input int d, input int id, input int b);
      return {16'hC0DE, 8'(d), 8'(b), 32'(id)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_cell(input int d, input int id, input bit exp_drop, input string req);
      for (int b = 0; b < 8; b++) begin
         @(negedge clk);
         if (b == 1) chk(drop_pulse == exp_drop, req, "drop flag", 64'(drop_pulse), 64'(exp_drop));
         in_valid = 1'b1;
         in_dest  = DW'(d);
         in_data  = mk(d, id, b);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_grant(input int d, input int id0, input int id1, input bit pad, input string req);
      @(negedge clk);
      grant = N'(1) << d;
      @(negedge clk);
      grant = '0;
      for (int b = 0; b < 16; b++) begin
         logic [63:0] exp;
         bit ok;
         @(negedge clk);
         exp = (b < 8) ? mk(d, id0, b) : (pad ? 64'd0 : mk(d, id1, b - 8));
         ok = out_valid && (out_dest == DW'(d)) && (out_data == exp) &&
              (out_pad == (pad && b >= 8)) && (out_last == (b == 15));
         chk(ok, req, $sformatf("dest %0d beat %0d", d, b), out_data, exp);
      end
   endtask

   task automatic no_xfer(input logic [N-1:0] g, input string req);
      bit seen = 1'b0;
      @(negedge clk);
      grant = g;
      @(negedge clk);
      grant = '0;
      repeat (20) begin
         @(negedge clk);
         if (out_valid) seen = 1'b1;
      end
      chk(!seen, req, "grant ignored", 64'(seen), 64'd0);
   endtask

   task automatic t_reset();
      chk(request == '0, "R1", "request after reset", 64'(request), 64'd0);
      chk(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      chk(!drop_pulse, "R1", "drop after reset", 64'(drop_pulse), 64'd0);
   endtask

   task automatic t_pair();
      send_cell(3, 1, 1'b0, "R2");
      chk(request[3] == 1'b0, "R3", "lone cell before timeout", 64'(request), 64'd0);
      send_cell(3, 2, 1'b0, "R2");
      chk(request == (N'(1) << 3), "R2", "pair requests", 64'(request), 64'(N'(1) << 3));
      do_grant(3, 1, 2, 1'b0, "R5");
      @(negedge clk);
      chk(request == '0, "R5", "drained request", 64'(request), 64'd0);
   endtask

   task automatic t_timeout();
      cfg_timeout = 12'd20;
      send_cell(5, 3, 1'b0, "R3");
      chk(request[5] == 1'b0, "R3", "fresh lone cell", 64'(request), 64'd0);
      repeat (22) @(negedge clk);
      chk(request[5] == 1'b1, "R3", "aged lone cell", 64'(request), 64'(N'(1) << 5));
      do_grant(5, 3, 0, 1'b1, "R6");
      cfg_timeout = 12'd1000;
   endtask

   task automatic t_inhibit();
      send_cell(1, 10, 1'b0, "R4");
      send_cell(1, 11, 1'b0, "R4");
      send_cell(4, 12, 1'b0, "R9");
      send_cell(4, 13, 1'b0, "R9");
      inhibit = N'(1) << 1;
      @(negedge clk);
      chk(request[1] == 1'b0, "R4", "inhibited request", 64'(request), 64'd0);
      chk(request[4] == 1'b1, "R9", "other dest unaffected", 64'(request), 64'(N'(1) << 4));
      no_xfer(N'(1) << 1, "R8");
      do_grant(4, 12, 13, 1'b0, "R9");
      inhibit = '0;
      @(negedge clk);
      chk(request == (N'(1) << 1), "R4", "request after release", 64'(request), 64'(N'(1) << 1));
      do_grant(1, 10, 11, 1'b0, "R4");
   endtask

   task automatic t_bad_grant();
      send_cell(6, 20, 1'b0, "R8");
      send_cell(6, 21, 1'b0, "R8");
      no_xfer((N'(1) << 6) | (N'(1) << 7), "R8");
      no_xfer('0, "R8");
      do_grant(6, 20, 21, 1'b0, "R8");
   endtask

   task automatic t_bad_dest();
      send_cell(15, 30, 1'b1, "R10");
      @(negedge clk);
      chk(request == '0, "R10", "no queue for bad dest", 64'(request), 64'd0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 16; i++) send_cell(2, 100 + i, 1'b0, "R7");
      send_cell(2, 116, 1'b1, "R7");
      for (int i = 0; i < 8; i++) do_grant(2, 100 + 2 * i, 101 + 2 * i, 1'b0, "R7");
      send_cell(2, 120, 1'b0, "R11");
      send_cell(2, 121, 1'b0, "R11");
      do_grant(2, 120, 121, 1'b0, "R11");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pair();
      t_timeout();
      t_inhibit();
      t_bad_grant();
      t_bad_dest();
      t_full();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule